// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block moves a small microcontroller core from ordinary execution into a reset or interrupt handler. While idle it watches a reset request, a vector of pending hardware sources and the core's global interrupt-enable flag. When the flag is set and something is requested, it captures the request, the pending vector and the current program counter in a single cycle. It then runs a fixed sequence.

The sequence writes the captured program counter onto a byte-wide stack in data memory. It writes one byte per clock, low byte first, each to the address held in a 16-bit stack pointer that then counts down. In the last step it presents the handler address for the program counter. In that same cycle it asks the core to clear the enable flag and reports which pending bit was serviced, so the owner of the pending register can drop it.

Build options set the number of stacked bytes (1, 2 or 3) and the handler slot size (1 or 2 words). Requests that arrive while a sequence runs have no effect on it. They are the requester's to hold.

Top module: `irq_entry_seq`

## Requirements
- R1: No sequence starts while gie_i is low: busy_o, mem_we_o and done_o stay low whatever rst_req_i and pend_i show.
- R2: For a hardware entry the serviced source is the lowest-numbered set bit n of pend_i. pend_clr_o carries only bit n (pend XOR (pend AND (pend-1))), and the other pending bits are left alone.
- R3: When rst_req_i and pend_i are both active in the starting cycle, reset wins: it uses vector 0 and pend_clr_o is zero.
- R4: The handler address on pc_o is vector times slot size, with base 0. Reset is vector 0 and source n is vector n+1. The slot size is 2 words when LONG_SLOT=1 and 1 word otherwise.
- R5: Stack writes carry the captured PC low byte first, then bits 15:8, then bits 23:16. Each write goes to the address in sp_o, and sp_o decrements by one after each write.
- R6: A sequence makes exactly PC_BYTES writes, on consecutive clocks, starting the cycle after the start condition is sampled.
- R7: done_o is a one-cycle pulse in the cycle right after the last write. pc_ld_o and gie_clr_o are high in exactly that cycle.
- R8: The stack pointer wraps modulo 2^16 when it decrements past zero.
- R9: rst_req_i, pend_i and pc_i are sampled only when the sequence starts. Changes during the sequence do not alter the written bytes, the vector or pend_clr_o.
- R10: After reset, sp_o equals SP_RST and busy_o, mem_we_o, done_o, pc_ld_o and gie_clr_o are low.
- R11: A pulse on sp_ld_i while idle loads sp_din_i into the stack pointer on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gie_i | input | 1 | Global interrupt-enable flag from the core |
| rst_req_i | input | 1 | Reset entry request |
| pend_i | input | N_SRC | Pending hardware sources, bit n is source n |
| pc_i | input | PC_W | Current program counter (return address) |
| sp_ld_i | input | 1 | Load stack pointer (honoured while idle) |
| sp_din_i | input | 16 | Value to load into the stack pointer |
| sp_o | output | 16 | Current stack pointer |
| mem_we_o | output | 1 | Stack byte write enable |
| mem_addr_o | output | 16 | Stack byte write address |
| mem_wdata_o | output | 8 | Stack byte write data |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-entry strobe |
| pc_ld_o | output | 1 | Load pc_o into the program counter |
| pc_o | output | PC_W | Handler address |
| gie_clr_o | output | 1 | Clear the global interrupt-enable flag |
| pend_clr_o | output | N_SRC | Mask of the serviced pending bit |

## Verification
The bench builds the block with PC_BYTES=3, LONG_SLOT=1, N_SRC=8 and PC_W=22. Three stacked bytes exercise the full push order, including the top byte. The two-word slot makes every vector show up as a doubled handler address, and the highest source reaches vector 8. Starting one push at stack address 1 drives the pointer through zero, so the wrap shows in the third write address and in the final pointer value.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PUSH = 2'd1,
    ST_DONE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N_SRC = 8,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] pend_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [N_SRC-1:0] win_o
);
  logic [N_SRC-1:0] rest;

  assign any_o = |pend_i;
  // lowest-set-bit removal; the removed bit is the winner
  assign rest  = pend_i & (pend_i - N_SRC'(1));
  assign win_o = pend_i ^ rest;

  always_comb begin
    idx_o = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (pend_i[i]) idx_o = IDX_W'(i);
    end
  end

  // R2
  win_onehot_chk: assert final ($onehot0(win_o));
endmodule

// File: rtl/irq_vec_addr.sv
module irq_vec_addr #(
  parameter int PC_W      = 16,
  parameter int VEC_W     = 4,
  parameter bit LONG_SLOT = 1'b1
) (
  input  logic [VEC_W-1:0] vec_i,
  output logic [PC_W-1:0]  addr_o
);
  localparam logic [PC_W-1:0] BASE = '0;

  generate
    if (LONG_SLOT) begin : g_long
      assign addr_o = BASE + (PC_W'(vec_i) << 1);
    end else begin : g_short
      assign addr_o = BASE + PC_W'(vec_i);
    end
  endgenerate
endmodule

// File: rtl/irq_push_ctrl.sv
module irq_push_ctrl #(
  parameter int PC_W     = 16,
  parameter int PC_BYTES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            active_i,
  input  logic [PC_W-1:0] pc_i,
  output logic [7:0]      data_o,
  output logic            last_o
);
  localparam int CNT_W = 2;

  logic [CNT_W-1:0] cnt_q;
  logic [23:0]      pc_q;
  logic [23:0]      shifted;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      pc_q  <= '0;
    end else if (start_i) begin
      cnt_q <= '0;
      pc_q  <= 24'(pc_i);
    end else if (active_i && !last_o) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign shifted = pc_q >> {cnt_q, 3'b000};
  assign data_o  = shifted[7:0];
  assign last_o  = (cnt_q == CNT_W'(PC_BYTES - 1));

  // R6
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i |-> (int'(cnt_q) < PC_BYTES));
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int          N_SRC     = 8,
  parameter int          PC_W      = 16,
  parameter int          PC_BYTES  = 2,
  parameter bit          LONG_SLOT = 1'b1,
  parameter logic [15:0] SP_RST    = 16'h0000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             gie_i,
  input  logic             rst_req_i,
  input  logic [N_SRC-1:0] pend_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic             sp_ld_i,
  input  logic [15:0]      sp_din_i,
  output logic [15:0]      sp_o,
  output logic             mem_we_o,
  output logic [15:0]      mem_addr_o,
  output logic [7:0]       mem_wdata_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             pc_ld_o,
  output logic [PC_W-1:0]  pc_o,
  output logic             gie_clr_o,
  output logic [N_SRC-1:0] pend_clr_o
);
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;
  localparam int VEC_W = $clog2(N_SRC + 1);

  seq_state_e       state_q, state_d;
  logic [15:0]      sp_q;
  logic [VEC_W-1:0] vec_q;
  logic [N_SRC-1:0] clr_q;
  logic             any_pend, start, push, last;
  logic [IDX_W-1:0] win_idx;
  logic [N_SRC-1:0] win_mask;

  irq_pick #(.N_SRC(N_SRC)) u_pick (
    .pend_i (pend_i),
    .any_o  (any_pend),
    .idx_o  (win_idx),
    .win_o  (win_mask)
  );

  irq_push_ctrl #(.PC_W(PC_W), .PC_BYTES(PC_BYTES)) u_push (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .active_i (push),
    .pc_i     (pc_i),
    .data_o   (mem_wdata_o),
    .last_o   (last)
  );

  irq_vec_addr #(.PC_W(PC_W), .VEC_W(VEC_W), .LONG_SLOT(LONG_SLOT)) u_vec (
    .vec_i  (vec_q),
    .addr_o (pc_o)
  );

  assign start = (state_q == ST_IDLE) && gie_i && (rst_req_i || any_pend);
  assign push  = (state_q == ST_PUSH);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start) state_d = ST_PUSH;
      ST_PUSH: if (last)  state_d = ST_DONE;
      default:            state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      vec_q   <= '0;
      clr_q   <= '0;
    end else begin
      state_q <= state_d;
      if (start) begin
        // reset outranks hardware sources
        vec_q <= rst_req_i ? '0 : VEC_W'(win_idx) + VEC_W'(1);
        clr_q <= rst_req_i ? '0 : win_mask;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               sp_q <= SP_RST;
    else if (sp_ld_i && state_q == ST_IDLE)    sp_q <= sp_din_i;
    else if (push)                             sp_q <= sp_q - 16'd1;
  end

  assign sp_o       = sp_q;
  assign mem_we_o   = push;
  assign mem_addr_o = sp_q;
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = (state_q == ST_DONE);
  assign pc_ld_o    = done_o;
  assign gie_clr_o  = done_o;
  assign pend_clr_o = done_o ? clr_q : '0;

  // R1
  no_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !gie_i) |=> !busy_o);
  // R5
  sp_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> (sp_o == $past(mem_addr_o) - 16'd1));
  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R7
  done_after_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(mem_we_o));
  // R3
  clr_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pend_clr_o));
  // R9
  vec_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(pc_o));
endmodule

// File: tb/sim_irq_entry_seq.sv
module sim_irq_entry_seq;
  localparam int N_SRC = 8;
  localparam int PC_W  = 22;
  localparam int NB    = 3;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             gie = 1'b0, rst_req = 1'b0, sp_ld = 1'b0;
  logic [N_SRC-1:0] pend = '0;
  logic [PC_W-1:0]  pc = '0;
  logic [15:0]      sp_din = '0;
  logic [15:0]      sp_o, mem_addr;
  logic             mem_we, busy, done, pc_ld, gie_clr;
  logic [7:0]       mem_wdata;
  logic [PC_W-1:0]  pc_o;
  logic [N_SRC-1:0] pend_clr;

  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  irq_entry_seq #(.N_SRC(N_SRC), .PC_W(PC_W), .PC_BYTES(NB), .LONG_SLOT(1'b1),
                  .SP_RST(16'h0000)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .gie_i(gie), .rst_req_i(rst_req),
    .pend_i(pend), .pc_i(pc), .sp_ld_i(sp_ld), .sp_din_i(sp_din), .sp_o(sp_o),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .busy_o(busy), .done_o(done), .pc_ld_o(pc_ld), .pc_o(pc_o),
    .gie_clr_o(gie_clr), .pend_clr_o(pend_clr));

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic load_sp(input logic [15:0] v);
    sp_din = v; sp_ld = 1'b1;
    @(negedge clk);
    sp_ld = 1'b0;
    chk(sp_o == v, "R11", "sp load", sp_o, v);
  endtask

  // inputs already applied at this negedge; pend_mid is shown during the push
  task automatic run_entry(input logic [PC_W-1:0] pc0, input logic [15:0] sp0,
                           input int vec, input logic [N_SRC-1:0] clr,
                           input logic [N_SRC-1:0] pend_mid, input string req);
    logic [23:0] pcx;
    pcx = 24'(pc0);
    @(negedge clk);
    rst_req = 1'b0; pend = pend_mid; pc = ~pc;
    for (int b = 0; b < NB; b++) begin
      chk(mem_we && busy, "R6", "write enable", {busy, mem_we}, 3);
      chk(mem_addr == sp0 - 16'(b), "R5", "write addr", mem_addr, sp0 - 16'(b));
      chk(mem_wdata == pcx[8*b +: 8], (b == 0) ? "R5" : "R9", "write byte",
          mem_wdata, pcx[8*b +: 8]);
      chk(!done, "R7", "early done", done, 0);
      @(negedge clk);
    end
    gie = 1'b0; pend = '0;
    chk(!mem_we, "R6", "extra write", mem_we, 0);
    chk(done && pc_ld && gie_clr, "R7", "done/ld/clr",
        {done, pc_ld, gie_clr}, 7);
    chk(pc_o == PC_W'(vec * 2), "R4", "handler addr", pc_o, vec * 2);
    chk(pend_clr == clr, req, "pend_clr", pend_clr, clr);
    chk(sp_o == sp0 - 16'(NB), "R8", "sp after push", sp_o, sp0 - 16'(NB));
    @(negedge clk);
    chk(!done && !pc_ld && !gie_clr && !busy, "R7", "done one cycle",
        {done, pc_ld, gie_clr, busy}, 0);
  endtask

  task automatic t_reset_state;
    chk(sp_o == 16'h0000, "R10", "sp reset", sp_o, 0);
    chk(!busy && !mem_we && !done && !pc_ld && !gie_clr, "R10", "outputs idle",
        {busy, mem_we, done, pc_ld, gie_clr}, 0);
  endtask

  task automatic t_gie_low;
    gie = 1'b0; rst_req = 1'b1; pend = 8'hFF;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!busy && !mem_we && !done, "R1", "entry while disabled",
          {busy, mem_we, done}, 0);
    end
    rst_req = 1'b0; pend = '0;
  endtask

  task automatic t_single;
    load_sp(16'h0100);
    pc = 22'h2A1B3C; pend = 8'h10; gie = 1'b1;
    run_entry(22'h2A1B3C, 16'h0100, 5, 8'h10, 8'h00, "R2");
  endtask

  task automatic t_multi_hold;
    load_sp(16'h0800);
    pc = 22'h012345; pend = 8'hA8; gie = 1'b1;
    run_entry(22'h012345, 16'h0800, 4, 8'h08, 8'h01, "R2");
  endtask

  task automatic t_reset_prio;
    load_sp(16'h0200);
    pc = 22'h3FFFFF; pend = 8'h01; rst_req = 1'b1; gie = 1'b1;
    run_entry(22'h3FFFFF, 16'h0200, 0, 8'h00, 8'h00, "R3");
  endtask

  task automatic t_wrap;
    load_sp(16'h0001);
    pc = 22'h00A5C3; pend = 8'h80; gie = 1'b1;
    run_entry(22'h00A5C3, 16'h0001, 8, 8'h80, 8'h00, "R2");
    chk(sp_o == 16'hFFFE, "R8", "sp wrap", sp_o, 16'hFFFE);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_gie_low();
    t_single();
    t_multi_hold();
    t_reset_prio();
    t_wrap();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule